// File: doc/BRIEF.md
# Miss-Correlation Prefetcher

This block watches the stream of cache-miss line addresses and learns which line tends to come next after a given recent history of misses. It keeps no arithmetic model of the addresses. Instead, a table of `ENTRIES` rows records up to `BREADTH` candidate successors per history, and each candidate has a 2-bit confidence counter. This lets it follow linked structures such as lists and trees, whose addresses have no stride. Each history is the XOR of the last `HIST_K` miss lines. Its low bits select a row, and the bits above them form a partial tag that keeps aliasing histories from producing predictions.

Each accepted miss does two things in turn. First, it trains the row named by the history *before* the miss, with the missing line as the observed successor. Then it looks up the row named by the history *after* the miss, and issues every sufficiently confident successor as a prefetch line address, one per cycle, highest confidence first. A small controller sequences this work with three states: `ST_IDLE` (ready for a miss), `ST_LOOKUP` (the new history reads its row) and `ST_ISSUE` (one prefetch per cycle). The transitions are:
- accept: `ST_IDLE` to `ST_LOOKUP` when a miss is taken.
- hit: `ST_LOOKUP` to `ST_ISSUE` when any candidate qualifies.
- none: `ST_LOOKUP` to `ST_IDLE` when no candidate qualifies.
- drain: `ST_ISSUE` to `ST_IDLE` once the last candidate has gone out.

`ST_ISSUE` otherwise stays where it is.

Top module: `corr_prefetch`

## Requirements
- R1: After reset, `miss_ready` is 1, `pf_valid` is 0, and every row and successor slot is invalid.
- R2: A miss is taken when `miss_valid` and `miss_ready` are both 1 at a clock edge. `miss_ready` is 0 from the next cycle until the lookup ends. The first prefetch, if any, is valid in the second cycle after the accepting edge, and further prefetches follow in consecutive cycles.
- R3: The history hash is the XOR of the low `IDX_W+TAG_W` bits of the last `HIST_K` accepted miss lines. Bits `[IDX_W-1:0]` select the row and bits `[IDX_W+TAG_W-1:IDX_W]` are its tag. No training happens until `HIST_K` misses have been seen before the current one, and no lookup happens until `HIST_K` misses have been seen including it.
- R4: When training finds a valid slot holding the missing line in a tag-matching row, that slot's counter is raised by one and saturates at 3.
- R5: When a tag-matching row has no slot holding the line, the victim slot is an invalid slot if one exists, otherwise the slot with the lowest counter (the lower slot number on a tie). The victim takes the line with counter 1.
- R6: When training finds an invalid row or a tag mismatch, the row is reallocated with the new tag. Slot 0 gets the line with counter 1 and all other slots become invalid.
- R7: Lookup qualifies only slots that are valid and have a counter of at least 2. Invalid or low-confidence slots give no prefetch.
- R8: Qualifying successors are issued in descending counter order. Among equal counters, the lower slot number goes first.
- R9: A lookup whose tag differs from the stored row tag issues no prefetch.
- R10: At most `BREADTH` prefetches follow one miss, and successive prefetches for one miss carry distinct lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss line address is offered |
| miss_line | input | LINE_W | Line address of the miss |
| miss_ready | output | 1 | Block can take a miss this cycle |
| pf_valid | output | 1 | A prefetch line address is issued this cycle |
| pf_line | output | LINE_W | Line address to prefetch |

## Verification
A repeating three-line cycle shows that nothing is predicted until a successor has been seen twice, and that prediction then starts on the third pass. Two sequences share a middle line but differ in their predecessors. They separate a two-miss history from a single-address history, since each context must yield only its own successor. One history fed two alternating successors with unequal counts checks issue order, victim choice and counter saturation. Finally, a history whose hash matches a trained row in its index but not its tag checks alias rejection, and the retraining that follows checks that the row is reallocated.

// File: rtl/corr_pf_pkg.sv
package corr_pf_pkg;

    localparam int          CONF_W      = 2;
    localparam logic [1:0]  CONF_MAX    = 2'd3;
    localparam logic [1:0]  CONF_INIT   = 2'd1;
    localparam logic [1:0]  CONF_THRESH = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ISSUE
    } pf_state_e;

endpackage

// File: rtl/corr_pf_history.sv
module corr_pf_history #(
    parameter int HASH_W = 12,
    parameter int HIST_K = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [HASH_W-1:0] line_bits,
    output logic [HASH_W-1:0] hash,
    output logic              full
);

    localparam int              FILL_W   = $clog2(HIST_K + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST_K);

    logic [HASH_W-1:0] hist_q [HIST_K];
    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_K; i++) hist_q[i] <= '0;
            fill_q <= '0;
        end else if (push) begin
            hist_q[0] <= line_bits;
            for (int i = 1; i < HIST_K; i++) hist_q[i] <= hist_q[i-1];
            if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
        end
    end

    always_comb begin
        hash = '0;
        for (int i = 0; i < HIST_K; i++) hash = hash ^ hist_q[i];
    end

    assign full = (fill_q == FILL_MAX);

endmodule

// File: rtl/corr_pf_table.sv
module corr_pf_table
    import corr_pf_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int BREADTH = 2,
    parameter int LINE_W  = 24,
    parameter int TAG_W   = 6,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VIC_W  = (BREADTH > 1) ? $clog2(BREADTH) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [IDX_W-1:0]                idx,
    input  logic [TAG_W-1:0]                tag,
    input  logic                            trn_en,
    input  logic [LINE_W-1:0]               trn_line,
    output logic                            tag_hit,
    output logic [BREADTH-1:0]              row_vld,
    output logic [BREADTH-1:0][CONF_W-1:0]  row_cnt,
    output logic [BREADTH-1:0][LINE_W-1:0]  row_line
);

    logic                            t_vld  [ENTRIES];
    logic [TAG_W-1:0]                t_tag  [ENTRIES];
    logic [BREADTH-1:0]              s_vld  [ENTRIES];
    logic [BREADTH-1:0][CONF_W-1:0]  s_cnt  [ENTRIES];
    logic [BREADTH-1:0][LINE_W-1:0]  s_line [ENTRIES];

    logic [BREADTH-1:0]              match;
    logic [VIC_W-1:0]                victim;
    logic [CONF_W:0]                 best_key;
    logic [BREADTH-1:0]              nx_vld;
    logic [BREADTH-1:0][CONF_W-1:0]  nx_cnt;
    logic [BREADTH-1:0][LINE_W-1:0]  nx_line;

    assign tag_hit  = t_vld[idx] && (t_tag[idx] == tag);
    assign row_vld  = s_vld[idx];
    assign row_cnt  = s_cnt[idx];
    assign row_line = s_line[idx];

    // victim: invalid slots rank below every valid one, then lowest count, then lowest slot
    always_comb begin
        victim   = '0;
        best_key = '1;
        for (int b = 0; b < BREADTH; b++) begin
            match[b] = row_vld[b] && (row_line[b] == trn_line);
            if ({row_vld[b], row_cnt[b]} < best_key) begin
                best_key = {row_vld[b], row_cnt[b]};
                victim   = VIC_W'(b);
            end
        end
    end

    always_comb begin
        nx_vld  = row_vld;
        nx_cnt  = row_cnt;
        nx_line = row_line;
        if (!tag_hit) begin
            nx_vld     = '0;
            nx_cnt     = '0;
            nx_vld[0]  = 1'b1;
            nx_cnt[0]  = CONF_INIT;
            nx_line[0] = trn_line;
        end else if (|match) begin
            for (int b = 0; b < BREADTH; b++) begin
                if (match[b] && (row_cnt[b] != CONF_MAX)) nx_cnt[b] = row_cnt[b] + 1'b1;
            end
        end else begin
            nx_vld[victim]  = 1'b1;
            nx_cnt[victim]  = CONF_INIT;
            nx_line[victim] = trn_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                t_vld[e]  <= 1'b0;
                t_tag[e]  <= '0;
                s_vld[e]  <= '0;
                s_cnt[e]  <= '0;
                s_line[e] <= '0;
            end
        end else if (trn_en) begin
            t_vld[idx]  <= 1'b1;
            t_tag[idx]  <= tag;
            s_vld[idx]  <= nx_vld;
            s_cnt[idx]  <= nx_cnt;
            s_line[idx] <= nx_line;
        end
    end

endmodule

// File: rtl/corr_pf_pick.sv
module corr_pf_pick
    import corr_pf_pkg::*;
#(
    parameter int BREADTH = 2,
    localparam int SEL_W  = (BREADTH > 1) ? $clog2(BREADTH) : 1
) (
    input  logic [BREADTH-1:0]             mask,
    input  logic [BREADTH-1:0][CONF_W-1:0] cnt,
    output logic [SEL_W-1:0]               sel,
    output logic [BREADTH-1:0]             sel_oh
);

    logic              found;
    logic [CONF_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        sel   = '0;
        for (int b = 0; b < BREADTH; b++) begin
            if (mask[b] && (!found || (cnt[b] > best))) begin
                found = 1'b1;
                best  = cnt[b];
                sel   = SEL_W'(b);
            end
        end
        sel_oh = '0;
        if (found) sel_oh[sel] = 1'b1;
    end

endmodule

// File: rtl/corr_prefetch.sv
module corr_prefetch
    import corr_pf_pkg::*;
#(
    parameter int LINE_W  = 24,
    parameter int ENTRIES = 64,
    parameter int BREADTH = 2,
    parameter int HIST_K  = 2,
    parameter int TAG_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    output logic              miss_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int HASH_W = IDX_W + TAG_W;
    localparam int SEL_W  = (BREADTH > 1) ? $clog2(BREADTH) : 1;

    pf_state_e state_q, state_d;

    logic                            accept;
    logic [HASH_W-1:0]               hash;
    logic                            hist_full;
    logic                            tag_hit;
    logic [BREADTH-1:0]              row_vld;
    logic [BREADTH-1:0][CONF_W-1:0]  row_cnt;
    logic [BREADTH-1:0][LINE_W-1:0]  row_line;
    logic [BREADTH-1:0]              elig;
    logic [BREADTH-1:0]              pend_q;
    logic [BREADTH-1:0]              sel_oh;
    logic [SEL_W-1:0]                sel;

    assign accept = miss_valid && (state_q == ST_IDLE);

    corr_pf_history #(
        .HASH_W (HASH_W),
        .HIST_K (HIST_K)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .line_bits (miss_line[HASH_W-1:0]),
        .hash      (hash),
        .full      (hist_full)
    );

    // Training uses the hash before the push; lookup reads it one cycle later
    corr_pf_table #(
        .ENTRIES (ENTRIES),
        .BREADTH (BREADTH),
        .LINE_W  (LINE_W),
        .TAG_W   (TAG_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (hash[IDX_W-1:0]),
        .tag      (hash[HASH_W-1:IDX_W]),
        .trn_en   (accept && hist_full),
        .trn_line (miss_line),
        .tag_hit  (tag_hit),
        .row_vld  (row_vld),
        .row_cnt  (row_cnt),
        .row_line (row_line)
    );

    generate
        for (genvar g = 0; g < BREADTH; g++) begin : g_elig
            assign elig[g] = hist_full && tag_hit && row_vld[g] && (row_cnt[g] >= CONF_THRESH);
        end
    endgenerate

    corr_pf_pick #(
        .BREADTH (BREADTH)
    ) u_pick (
        .mask   (pend_q),
        .cnt    (row_cnt),
        .sel    (sel),
        .sel_oh (sel_oh)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = (|elig) ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:  if ((pend_q & ~sel_oh) == '0) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOOKUP: pend_q <= elig;
                ST_ISSUE:  pend_q <= pend_q & ~sel_oh;
                default:   pend_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        miss_ready = (state_q == ST_IDLE);
        pf_valid   = (state_q == ST_ISSUE);
        pf_line    = row_line[sel];
    end

endmodule

// File: rtl/corr_prefetch_checker.sv
module corr_prefetch_checker #(
    parameter int LINE_W  = 24,
    parameter int BREADTH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              pf_valid,
    input logic [LINE_W-1:0] pf_line
);

    localparam int CNT_W = $clog2(BREADTH + 1) + 1;

    logic [CNT_W-1:0] issued_q;
    logic             taken;

    assign taken = miss_valid && miss_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)        issued_q <= '0;
        else if (taken)    issued_q <= '0;
        else if (pf_valid) issued_q <= issued_q + 1'b1;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) taken |=> !miss_ready); // R2
    AST_QUIET_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n) taken |=> !pf_valid); // R2
    AST_PF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) pf_valid |-> !miss_ready); // R2
    AST_PF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) pf_valid |-> (int'(issued_q) < BREADTH)); // R10
    AST_PF_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n) (pf_valid && $past(pf_valid)) |-> (pf_line != $past(pf_line))); // R10

endmodule

bind corr_prefetch corr_prefetch_checker #(
    .LINE_W  (LINE_W),
    .BREADTH (BREADTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .pf_valid   (pf_valid),
    .pf_line    (pf_line)
);

// File: tb/corr_prefetch_bench.sv
`timescale 1ns/1ps
module corr_prefetch_bench;

    localparam int LW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [LW-1:0] miss_line = '0;
    logic          miss_ready;
    logic          pf_valid;
    logic [LW-1:0] pf_line;

    int            checks = 0;
    int            failures = 0;
    int            pf_n;
    int            pf_first;
    logic [LW-1:0] got [4];

    always #10 clk = ~clk;

    corr_prefetch u_corr_prefetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_line  (miss_line),
        .miss_ready (miss_ready),
        .pf_valid   (pf_valid),
        .pf_line    (pf_line)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        miss_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // offers one miss at a negedge, then records every prefetch until ready returns
    task automatic send(input logic [LW-1:0] a);
        int k;
        miss_valid = 1'b1;
        miss_line  = a;
        @(negedge clk);
        miss_valid = 1'b0;
        pf_n = 0;
        pf_first = 0;
        k = 1;
        forever begin
            if (pf_valid) begin
                if (pf_n < 4) got[pf_n] = pf_line;
                if (pf_n == 0) pf_first = k;
                pf_n++;
            end
            if (miss_ready) break;
            @(negedge clk);
            k++;
        end
    endtask

    task automatic expect_pf(input string req, input int n, input logic [LW-1:0] e0, input logic [LW-1:0] e1);
        chk(pf_n == n, {req, " count"}, pf_n, n);
        if (n > 0 && pf_n > 0) chk(got[0] == e0, {req, " first"}, got[0], e0);
        if (n > 1 && pf_n > 1) chk(got[1] == e1, {req, " second"}, got[1], e1);
    endtask

    task automatic t_reset();
        do_reset();
        chk(miss_ready == 1'b1, "R1 ready", miss_ready, 1);
        chk(pf_valid == 1'b0, "R1 pf_valid", pf_valid, 0);
        send(24'h000101);
        expect_pf("R1 empty", 0, 0, 0);
    endtask

    task automatic t_chain();
        logic [LW-1:0] seq [3] = '{24'h000101, 24'h000202, 24'h000404};
        int zeros = 0;
        do_reset();
        for (int i = 0; i < 7; i++) begin
            send(seq[i % 3]);
            if (pf_n == 0) zeros++;
        end
        chk(zeros == 7, "R7 no prefetch below confidence 2", zeros, 7);
        send(seq[1]);
        expect_pf("R3 chain successor", 1, seq[2], 0);
        chk(pf_first == 2, "R2 first prefetch latency", pf_first, 2);
        send(seq[2]);
        expect_pf("R3 chain wraps", 1, seq[0], 0);
    endtask

    task automatic t_context();
        logic [LW-1:0] seq [6] = '{24'h01, 24'h02, 24'h04, 24'h08, 24'h02, 24'h10};
        do_reset();
        for (int i = 0; i < 12; i++) send(seq[i % 6]);
        send(seq[0]);
        send(seq[1]);
        expect_pf("R3 context P,Q", 1, seq[2], 0);
        send(seq[2]);
        send(seq[3]);
        send(seq[4]);
        expect_pf("R3 context S,Q", 1, seq[5], 0);
    endtask

    task automatic t_order();
        logic [LW-1:0] x = 24'h011, y = 24'h022;
        logic [LW-1:0] e1 = 24'h044, e2 = 24'h088, e3 = 24'h0F0;
        logic [LW-1:0] succ [5] = '{24'h044, 24'h088, 24'h088, 24'h044, 24'h088};
        do_reset();
        for (int g = 0; g < 5; g++) begin
            send(x);
            send(y);
            if (g == 3) expect_pf("R7 only confident slot", 1, e2, 0);
            send(succ[g]);
        end
        send(x);
        send(y);
        expect_pf("R8 highest count first", 2, e2, e1);
        chk(pf_first == 2, "R2 burst latency", pf_first, 2);
        send(e3);
        send(x);
        send(y);
        expect_pf("R5 lowest count replaced", 1, e2, 0);
        send(e2);
        send(x);
        send(y);
        expect_pf("R4 counter saturates", 1, e2, 0);
    endtask

    task automatic t_alias();
        logic [LW-1:0] x = 24'h011, y = 24'h022, e1 = 24'h044;
        logic [LW-1:0] v = 24'h040, w = 24'h033;
        do_reset();
        for (int g = 0; g < 2; g++) begin
            send(x);
            send(y);
            send(e1);
        end
        send(x);
        send(y);
        expect_pf("R7 trained pair", 1, e1, 0);
        send(v);
        send(w);
        expect_pf("R9 tag mismatch", 0, 0, 0);
        send(x);
        send(v);
        send(w);
        send(x);
        send(v);
        send(w);
        expect_pf("R6 reallocated row", 1, x, 0);
        send(x);
        send(y);
        expect_pf("R6 old tag dropped", 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_chain();
        t_context();
        t_order();
        t_alias();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule